// File: doc/BRIEF.md
# Indirect Branch Target Table

This block guesses where an indirect branch will go. It keeps a direct-mapped table of targets it has seen before. A slice of the branch address selects the entry. Each request carries the branch address and the target that the branch actually resolved to. The block compares the stored target with the actual one and reports a mispredict when the two differ. It then writes the actual target into the entry in every case.

Entries carry no tag and no valid bit. Two branches whose address slices match use the same entry. After reset every entry holds zero, so the first visit to an entry mispredicts unless the actual target is zero. The result is registered: a valid pulse with the mispredict flag appears one cycle after each request.

Top module: `ibt_table`

## Requirements
- R1: The table has 2^IDX_W entries (512 by default). Each entry holds a full ADDR_W-bit target (32 by default).
- R2: The entry index is bits [ALIGN_SHIFT+IDX_W-1 : ALIGN_SHIFT] of the branch address. ALIGN_SHIFT is a parameter of 0, 1 or 2. Address bits outside that slice have no effect on which entry is used.
- R3: `res_valid_o` is 1 in the cycle after a clock edge that sampled `req_valid_i`=1, and 0 otherwise.
- R4: When `res_valid_o` is 1, `res_mispred_o` is 1 exactly when the entry held a target different from the request's actual target.
- R5: Every request writes its actual target into its entry, whether the prediction was right or wrong.
- R6: A synchronous active-low reset clears every entry to zero and clears `res_valid_o`. A first access with actual target zero then predicts correctly, and any nonzero target mispredicts.
- R7: A request in the cycle right after a write to the same index compares against the newly written target.
- R8: Branches that alias to one index share an entry, so each overwrites the other's target.
- R9: In a cycle with `req_valid_i`=0, no entry changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_pc_i | input | ADDR_W | Branch instruction address |
| req_target_i | input | ADDR_W | Resolved actual target |
| res_valid_o | output | 1 | Result valid, one cycle after the request |
| res_mispred_o | output | 1 | Stored target differed from the actual target |

## Verification
The embedded assertions check on every cycle that the result valid follows the request by exactly one cycle. They also check that the mispredict flag is never raised without a valid result, and that the written entry equals the request's target. Whether the flag is correct depends on the history of each entry. That covers the zero start after reset, back-to-back same-index requests, aliasing addresses, ignored low and high address bits, and idle cycles leaving the table untouched. Only the bench's directed scenarios can show these.

// File: rtl/ibt_pkg.sv
// Package: shared parameters and helper for the indirect target table.
// Assumes: ALIGN_SHIFT is 0, 1 or 2.
package ibt_pkg;
    localparam int unsigned DEF_ADDR_W = 32;
    localparam int unsigned DEF_IDX_W  = 9;
    localparam int unsigned DEF_ALIGN  = 2;
endpackage

// File: rtl/ibt_index.sv
// Module: ibt_index
// Forms the table index from a branch address. It drops the always-zero
// low bits and keeps the next IDX_W bits.
// Assumes: ADDR_W >= ALIGN_SHIFT + IDX_W.
module ibt_index #(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned IDX_W       = 9,
    parameter int unsigned ALIGN_SHIFT = 2
) (
    input  logic [ADDR_W-1:0] pc_i,
    output logic [IDX_W-1:0]  idx_o
);
    localparam int unsigned LO = ALIGN_SHIFT;
    localparam int unsigned HI = ALIGN_SHIFT + IDX_W - 1;

    // Select the index slice
    always_comb idx_o = pc_i[HI:LO];

    initial begin
        assert (ALIGN_SHIFT <= 2) else $error("ALIGN_SHIFT must be 0..2");
        assert (ADDR_W >= ALIGN_SHIFT + IDX_W) else $error("ADDR_W too small");
    end
endmodule

// File: rtl/ibt_store.sv
// Module: ibt_store
// Target storage: DEPTH words of ADDR_W bits with one async read port and
// one sync write port.
// Reset: a synchronous active-low reset zeroes every word.
// Assumes: read and write use the same index during a request, so the read
// sees the old contents before the edge.
module ibt_store #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned IDX_W  = 9
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic [ADDR_W-1:0] rd_data_o,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [ADDR_W-1:0] wr_data_i
);
    localparam int unsigned DEPTH = 1 << IDX_W;

    logic [ADDR_W-1:0] mem_q [DEPTH];

    // Read the selected word combinationally
    always_comb rd_data_o = mem_q[rd_idx_i];

    // Clear on reset, otherwise write one word on request
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (wr_en_i) begin
            mem_q[wr_idx_i] <= wr_data_i;
        end
    end

    // R5: after a write the addressed word holds the written data
    p_write_lands_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_i |=> mem_q[$past(wr_idx_i)] == $past(wr_data_i));
endmodule

// File: rtl/ibt_compare.sv
// Module: ibt_compare
// Compares the stored and actual targets and registers the result with a
// valid flag one cycle after the request.
// Reset: a synchronous active-low reset clears the valid flag.
module ibt_compare #(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_valid_i,
    input  logic [ADDR_W-1:0] stored_i,
    input  logic [ADDR_W-1:0] actual_i,
    output logic              res_valid_o,
    output logic              res_mispred_o
);
    logic miss;

    // Raw inequality of the stored and actual targets
    always_comb miss = (stored_i != actual_i);

    // Register the result and its valid flag
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            res_valid_o   <= 1'b0;
            res_mispred_o <= 1'b0;
        end else begin
            res_valid_o   <= req_valid_i;
            res_mispred_o <= req_valid_i & miss;
        end
    end

    // R3: a result follows every request by exactly one cycle
    p_valid_follows_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_valid_i |=> res_valid_o);
    // R3: no result without a request in the previous cycle
    p_no_spurious_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !req_valid_i |=> !res_valid_o);
    // R4: the mispredict flag is raised only together with a valid result
    p_mispred_qualified_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        res_mispred_o |-> res_valid_o);
endmodule

// File: rtl/ibt_table.sv
// Module: ibt_table (top)
// Untagged direct-mapped indirect branch target table. It compares the
// stored target with the actual one, reports a mispredict, and always
// writes the actual target back into the entry.
// Reset: synchronous active-low; clears all entries and the result.
// Assumes: one request per cycle at most; the request's index is used for
// both the read and the write.
module ibt_table #(
    parameter int unsigned ADDR_W      = ibt_pkg::DEF_ADDR_W,
    parameter int unsigned IDX_W       = ibt_pkg::DEF_IDX_W,
    parameter int unsigned ALIGN_SHIFT = ibt_pkg::DEF_ALIGN
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_valid_i,
    input  logic [ADDR_W-1:0] req_pc_i,
    input  logic [ADDR_W-1:0] req_target_i,
    output logic              res_valid_o,
    output logic              res_mispred_o
);
    logic [IDX_W-1:0]  idx;
    logic [ADDR_W-1:0] stored;

    ibt_index #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .ALIGN_SHIFT(ALIGN_SHIFT)) u_index (
        .pc_i  (req_pc_i),
        .idx_o (idx)
    );

    ibt_store #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_store (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .rd_idx_i  (idx),
        .rd_data_o (stored),
        .wr_en_i   (req_valid_i),
        .wr_idx_i  (idx),
        .wr_data_i (req_target_i)
    );

    ibt_compare #(.ADDR_W(ADDR_W)) u_cmp (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .req_valid_i   (req_valid_i),
        .stored_i      (stored),
        .actual_i      (req_target_i),
        .res_valid_o   (res_valid_o),
        .res_mispred_o (res_mispred_o)
    );

    // R7: a repeat of the same branch and target right after a request hits
    p_b2b_hit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && $past(req_valid_i) && $past(rst_ni)
         && idx == $past(idx) && req_target_i == $past(req_target_i))
        |=> (res_valid_o && !res_mispred_o));
endmodule

// File: tb/test_ibt_table.sv
module test_ibt_table;
    localparam int  ADDR_W = 32;
    localparam int  IDX_W  = 9;
    localparam int  SH     = 2;
    localparam time TCLK   = 10ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vld = 1'b0;
    logic [ADDR_W-1:0] pc = '0;
    logic [ADDR_W-1:0] tg = '0;
    logic rv, rm;
    int errors = 0;
    int checks = 0;

    always #(TCLK/2) clk = ~clk;

    ibt_table #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .ALIGN_SHIFT(SH)) i_ibt_table (
        .clk_i(clk), .rst_ni(rst_n), .req_valid_i(vld), .req_pc_i(pc),
        .req_target_i(tg), .res_valid_o(rv), .res_mispred_o(rm)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b", req, act, exp);
        end
    endtask

    // Drive one request. Inputs change at negedge; result sampled at the next negedge.
    task automatic access(input logic [ADDR_W-1:0] a, input logic [ADDR_W-1:0] t,
                          input logic exp_m, input string req);
        @(negedge clk);
        vld = 1'b1; pc = a; tg = t;
        @(negedge clk);
        vld = 1'b0;
        check(req, rv, 1'b1);
        check(req, rm, exp_m);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    // R6: after reset the result is invalid; zero target hits, nonzero misses
    task automatic t_reset();
        do_reset();
        check("R6 valid low after reset", rv, 1'b0);
        access(32'h0000_1000, 32'h0, 1'b0, "R6 zero target hits fresh entry");
        access(32'h0000_1004, 32'hDEAD_BEE0, 1'b1, "R6 fresh entry misses");
    endtask

    // R4 R5: a miss writes the target back, a repeat hits, a change misses
    task automatic t_basic();
        access(32'h0000_2008, 32'h1234_5678, 1'b1, "R4 first miss");
        access(32'h0000_2008, 32'h1234_5678, 1'b0, "R5 stored after miss");
        access(32'h0000_2008, 32'h8765_4320, 1'b1, "R4 changed target");
        access(32'h0000_2008, 32'h8765_4320, 1'b0, "R5 overwrite on miss");
    endtask

    // R7: back-to-back requests to one index, no idle cycle between them
    task automatic t_b2b();
        @(negedge clk);
        vld = 1'b1; pc = 32'h0000_3010; tg = 32'hAAAA_0000;
        @(negedge clk);
        check("R7 first b2b", rm, 1'b1);
        tg = 32'hAAAA_0000;
        @(negedge clk);
        check("R7 b2b sees new target", rm, 1'b0);
        tg = 32'h5555_0000;
        @(negedge clk);
        vld = 1'b0;
        check("R7 b2b change", rm, 1'b1);
        @(negedge clk);
        check("R3 valid drops", rv, 1'b0);
    endtask

    // R2 R8: addresses equal in bits [10:2] alias; low bits and high bits ignored
    task automatic t_alias();
        access(32'h0000_4020, 32'h0BAD_0000, 1'b1, "R8 seed");
        access(32'h0000_4023, 32'h0BAD_0000, 1'b0, "R2 low bits ignored");
        access(32'hFFFF_C020, 32'h0BAD_0000, 1'b0, "R2 high bits ignored");
        access(32'h0000_4820, 32'h0C0D_0000, 1'b1, "R8 alias overwrites");
        access(32'h0000_4020, 32'h0BAD_0000, 1'b1, "R8 original lost");
        access(32'h0000_4024, 32'h0BAD_0000, 1'b1, "R2 neighbour index distinct");
    endtask

    // R9: idle cycles with changing inputs leave the table untouched
    task automatic t_idle();
        access(32'h0000_5000, 32'h7777_0000, 1'b1, "R9 seed");
        @(negedge clk);
        vld = 1'b0; pc = 32'h0000_5000; tg = 32'h1111_1111;
        repeat (3) @(negedge clk);
        check("R3 idle no valid", rv, 1'b0);
        access(32'h0000_5000, 32'h7777_0000, 1'b0, "R9 entry unchanged by idle");
    endtask

    // R1: fill every entry, then confirm each one held its own target
    task automatic t_full();
        for (int i = 0; i < (1 << IDX_W); i++) begin
            @(negedge clk);
            vld = 1'b1; pc = ADDR_W'(i << SH); tg = ADDR_W'(32'h9000_0000 + i);
        end
        @(negedge clk); vld = 1'b0;
        for (int i = 0; i < (1 << IDX_W); i += 37)
            access(ADDR_W'(i << SH), ADDR_W'(32'h9000_0000 + i), 1'b0, "R1 entry retained");
        access(ADDR_W'(((1 << IDX_W) - 1) << SH), ADDR_W'(32'h9000_0000 + (1 << IDX_W) - 1),
               1'b0, "R1 top entry retained");
        // R6: reset clears the filled table
        do_reset();
        access(32'h0000_0004, 32'h9000_0001, 1'b1, "R6 reset clears table");
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_basic();
                t_b2b();
                t_alias();
                t_idle();
                t_full();
            end
            begin
                repeat (100000) @(posedge clk);
                errors++; checks++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        disable fork;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule